// File: doc/BRIEF.md
# SMRAM and TSEG Access Router

This block sits between a memory-request source and the memory system of a host bridge. It holds two configuration bytes that control access to system-management memory: a primary control byte (open, lock and global-enable bits) and an extended control byte (high-alias enable and a protected top-of-memory segment with a programmable size). For every request it takes the address and a flag that says whether the requester is in system-management mode. From these and the two bytes it decides where the request goes: to DRAM, to the PCI/VGA side, or to a sink that returns all-ones on reads and drops writes.

Three regions are covered. The first is the 128 KB legacy window at 0xA0000 to 0xBFFFF. The second is its high alias at 0xFEDA0000, which reaches the same DRAM bytes. The third is a protected segment that ends at the below-4G memory boundary. A lock bit freezes the configuration until reset. The route is combinational, so a request is steered in the cycle it is presented. Configuration writes take effect from the next clock edge. The block has no handshake: the route follows the address and the mode flag, and the requester samples it when it needs it.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: After reset both control bytes read 0x00, and the lock bit is clear.
- R2: While unlocked, a write to the primary byte (select 0) changes only bit 6 (open), bit 4 (lock) and bit 3 (global enable). A write to the extended byte (select 1) changes only bit 7 (high enable), bits 2:1 (segment size code) and bit 0 (segment enable). All other bits read 0. The new value is visible on the outputs after the next rising clock edge.
- R3: When the primary byte holds a 1 in bit 4 (lock), bit 6 (open) reads 0, including in the write that sets the lock. Once locked, writes to either byte have no effect. Only reset clears the lock.
- R4: A non-SMM access to 0xA0000..0xBFFFF goes to DRAM when open=1 and high enable=0. Otherwise it goes to PCI/VGA.
- R5: A non-SMM access to 0xFEDA0000..0xFEDBFFFF goes to DRAM when open=1 and high enable=1. Otherwise it goes to PCI/VGA. A DRAM-routed access to this alias carries the DRAM address `addr - 0xFEDA0000 + 0xA0000`.
- R6: With global enable set, an SMM access reaches DRAM through the low window when high enable=0, and through the high alias when high enable=1. In every other case an SMM access to these windows is routed exactly as a non-SMM access would be.
- R7: The segment size is 0 when segment enable is 0. With enable set, size code 0 means 1 MB, 1 means 2 MB, 2 means 8 MB and 3 means 0. The segment covers `[mem_top - size, mem_top)`.
- R8: A non-SMM access inside the segment is routed to the sink, and an SMM access inside it goes to DRAM.
- R9: Any other address goes to DRAM below `mem_top` and to PCI/VGA at or above it, with the DRAM address equal to the request address.
- R10: The route code is 0 for DRAM, 1 for PCI/VGA and 2 for the sink. Code 3 never appears. The route follows a change of address or mode flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | 0 selects the primary byte, 1 selects the extended byte |
| cfg_wdata | input | 8 | Write data |
| smram_ctl | output | 8 | Current primary control byte |
| ext_ctl | output | 8 | Current extended control byte |
| mem_top | input | AW | Below-4G memory size, static, aligned to 1 MB |
| acc_addr | input | AW | Request address |
| acc_smm | input | 1 | Request comes from system-management mode |
| route | output | 2 | Route code (0 DRAM, 1 PCI/VGA, 2 sink) |
| dram_addr | output | AW | Address presented to DRAM |

## Verification
The route and the DRAM address have no register on their path. The bench therefore drives the address and the mode flag just after a falling edge and compares both results a few nanoseconds later, inside the same cycle. A configuration write is driven at one falling edge and captured at the following rising edge. The bench reads back the control bytes at the next falling edge, and every later route check uses the value of the bench's own register model from that point on. The segment edges (base minus one, base, top minus one, top) are checked for each size code, in both modes.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    RT_DRAM = 2'b00,
    RT_PCI  = 2'b01,
    RT_HOLE = 2'b10
  } route_e;

  // primary byte bit positions
  localparam int P_OPEN = 6;
  localparam int P_LOCK = 4;
  localparam int P_GEN  = 3;
  // extended byte bit positions
  localparam int X_HEN  = 7;
  localparam int X_SZHI = 2;
  localparam int X_SZLO = 1;
  localparam int X_TEN  = 0;

  localparam logic [7:0] PRI_RST     = 8'h00;
  localparam logic [7:0] EXT_RST     = 8'h00;
  localparam logic [7:0] PRI_WM_FREE = 8'h58;
  localparam logic [7:0] PRI_WM_LOCK = 8'h00;
  localparam logic [7:0] EXT_WM_FREE = 8'h87;
  localparam logic [7:0] EXT_WM_LOCK = 8'h00;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] pri_q,
  output logic [7:0] ext_q
);
  localparam int NREG = 2;

  logic        locked;
  logic [7:0]  cur   [NREG];
  logic [7:0]  nxt   [NREG];
  logic [7:0]  wmask [NREG];
  logic [7:0]  rstv  [NREG];

  assign locked   = pri_q[P_LOCK];
  assign wmask[0] = locked ? PRI_WM_LOCK : PRI_WM_FREE;
  assign wmask[1] = locked ? EXT_WM_LOCK : EXT_WM_FREE;
  assign rstv[0]  = PRI_RST;
  assign rstv[1]  = EXT_RST;
  assign cur[0]   = pri_q;
  assign cur[1]   = ext_q;

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    logic [7:0] merged;
    logic [7:0] q;
    always_comb begin
      merged = (cur[g] & ~wmask[g]) | (wdata & wmask[g]);
      if (g == 0 && merged[P_LOCK]) merged[P_OPEN] = 1'b0;
      nxt[g] = (we && (sel == 1'(g))) ? merged : cur[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= rstv[g];
      else        q <= nxt[g];
    end
  end

  assign pri_q = g_byte[0].q;
  assign ext_q = g_byte[1].q;
endmodule

// File: rtl/smram_range_hit.sv
module smram_range_hit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size,
  output logic          hit
);
  logic [AW-1:0] off;
  assign off = addr - base;
  assign hit = (addr >= base) && (off < size);
endmodule

// File: rtl/smram_tseg_size.sv
module smram_tseg_size #(
  parameter int AW       = 32,
  parameter int MB_SHIFT = 20
) (
  input  logic          en,
  input  logic [1:0]    code,
  output logic [AW-1:0] size
);
  localparam logic [AW-1:0] ONE_MB = AW'(1) << MB_SHIFT;
  always_comb begin
    size = '0;
    if (en) begin
      unique case (code)
        2'd0:    size = ONE_MB;
        2'd1:    size = ONE_MB << 1;
        2'd2:    size = ONE_MB << 3;
        default: size = '0;
      endcase
    end
  end
endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl
  import smram_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MB_SHIFT  = 20,
  parameter logic [AW-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [AW-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [AW-1:0] WIN_SIZE  = 32'h0002_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    smram_ctl,
  output logic [7:0]    ext_ctl,
  input  logic [AW-1:0] mem_top,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_smm,
  output logic [1:0]    route,
  output logic [AW-1:0] dram_addr
);
  localparam logic [AW-1:0] ALIAS_DELTA = HIGH_BASE - LOW_BASE;

  logic [AW-1:0] tseg_sz, tseg_base;
  logic          hit_low, hit_high, hit_tseg;
  logic          open_b, gen_b, hen_b;
  route_e        rt;

  smram_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .pri_q(smram_ctl), .ext_q(ext_ctl)
  );

  smram_tseg_size #(.AW(AW), .MB_SHIFT(MB_SHIFT)) u_tsz (
    .en(ext_ctl[X_TEN]), .code(ext_ctl[X_SZHI:X_SZLO]), .size(tseg_sz)
  );

  assign tseg_base = mem_top - tseg_sz;

  smram_range_hit #(.AW(AW)) u_low (
    .addr(acc_addr), .base(LOW_BASE), .size(WIN_SIZE), .hit(hit_low));
  smram_range_hit #(.AW(AW)) u_high (
    .addr(acc_addr), .base(HIGH_BASE), .size(WIN_SIZE), .hit(hit_high));
  smram_range_hit #(.AW(AW)) u_tseg (
    .addr(acc_addr), .base(tseg_base), .size(tseg_sz), .hit(hit_tseg));

  assign open_b = smram_ctl[P_OPEN];
  assign gen_b  = smram_ctl[P_GEN];
  assign hen_b  = ext_ctl[X_HEN];

  always_comb begin
    if (hit_low) begin
      if (acc_smm && gen_b && !hen_b)  rt = RT_DRAM;
      else if (open_b && !hen_b)       rt = RT_DRAM;
      else                             rt = RT_PCI;
    end else if (hit_high) begin
      if (acc_smm && gen_b && hen_b)   rt = RT_DRAM;
      else if (open_b && hen_b)        rt = RT_DRAM;
      else                             rt = RT_PCI;
    end else if (hit_tseg) begin
      rt = acc_smm ? RT_DRAM : RT_HOLE;
    end else begin
      rt = (acc_addr < mem_top) ? RT_DRAM : RT_PCI;
    end
  end

  assign route     = rt;
  assign dram_addr = hit_high ? (acc_addr - ALIAS_DELTA) : acc_addr;
endmodule

// File: rtl/smram_tseg_ctrl_chk.sv
module smram_tseg_ctrl_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [AW-1:0] HIGH_BASE = 32'hFEDA_0000,
  parameter logic [AW-1:0] WIN_SIZE  = 32'h0002_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    smram_ctl,
  input logic [7:0]    ext_ctl,
  input logic [AW-1:0] acc_addr,
  input logic          acc_smm,
  input logic [1:0]    route,
  input logic [AW-1:0] dram_addr
);
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smram_ctl[4]) |-> smram_ctl[4]);

  p_lock_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smram_ctl[4] |-> !smram_ctl[6]);

  p_lock_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smram_ctl[4] |=> ($stable(smram_ctl) && $stable(ext_ctl)));

  p_hole_not_smm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route == 2'b10) |-> !acc_smm);

  p_route_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    route != 2'b11);

  p_alias_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_addr >= HIGH_BASE) && (acc_addr - HIGH_BASE < WIN_SIZE) && route == 2'b00)
      |-> ((dram_addr >= LOW_BASE) && (dram_addr - LOW_BASE < WIN_SIZE)));

  p_free_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((smram_ctl & 8'hA7) == 8'h00) && ((ext_ctl & 8'h78) == 8'h00));
endmodule

bind smram_tseg_ctrl smram_tseg_ctrl_chk #(
  .AW(AW), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE), .WIN_SIZE(WIN_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smram_ctl(smram_ctl), .ext_ctl(ext_ctl),
  .acc_addr(acc_addr), .acc_smm(acc_smm), .route(route), .dram_addr(dram_addr)
);

// File: tb/smram_tseg_ctrl_test.sv
module smram_tseg_ctrl_test;
  localparam logic [31:0] TOP  = 32'h8000_0000;
  localparam logic [31:0] LOWB = 32'h000A_0000;
  localparam logic [31:0] HIB  = 32'hFEDA_0000;
  localparam logic [31:0] WIN  = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  smram_ctl, ext_ctl;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_smm = 1'b0;
  logic [1:0]  route;
  logic [31:0] dram_addr;

  int total = 0;
  int bad = 0;
  logic [7:0] m_pri = 8'h00, m_ext = 8'h00;

  always #10 clk = ~clk;

  smram_tseg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .smram_ctl(smram_ctl), .ext_ctl(ext_ctl),
    .mem_top(TOP), .acc_addr(acc_addr), .acc_smm(acc_smm),
    .route(route), .dram_addr(dram_addr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seg_size(input logic [7:0] x);
    if (!x[0]) return 32'h0;
    case (x[2:1])
      2'd0: return 32'h0010_0000;
      2'd1: return 32'h0020_0000;
      2'd2: return 32'h0080_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit in_low(input logic [31:0] a);
    return a >= LOWB && a < LOWB + WIN;
  endfunction
  function automatic bit in_high(input logic [31:0] a);
    return a >= HIB && a < HIB + WIN;
  endfunction

  function automatic logic [1:0] exp_route(input logic [31:0] a, input logic s);
    logic [31:0] sz;
    bit op, ge, he;
    op = m_pri[6]; ge = m_pri[3]; he = m_ext[7];
    sz = seg_size(m_ext);
    if (in_low(a)) begin
      if (s && ge && !he) return 2'd0;
      return (op && !he) ? 2'd0 : 2'd1;
    end
    if (in_high(a)) begin
      if (s && ge && he) return 2'd0;
      return (op && he) ? 2'd0 : 2'd1;
    end
    if (sz != 0 && a >= TOP - sz && a < TOP) return s ? 2'd0 : 2'd2;
    return (a < TOP) ? 2'd0 : 2'd1;
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic s);
    logic [31:0] sz;
    sz = seg_size(m_ext);
    if (in_low(a))  return s ? "R6" : "R4";
    if (in_high(a)) return s ? "R6" : "R5";
    if (sz != 0 && a >= TOP - sz && a < TOP) return "R8";
    return "R9";
  endfunction

  task automatic model_write(input logic sel, input logic [7:0] d);
    logic [7:0] m, nv;
    if (!sel) begin
      m  = m_pri[4] ? 8'h00 : 8'h58;
      nv = (m_pri & ~m) | (d & m);
      if (nv[4]) nv[6] = 1'b0;
      m_pri = nv;
    end else begin
      m  = m_pri[4] ? 8'h00 : 8'h87;
      m_ext = (m_ext & ~m) | (d & m);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(sel, d);
    #2;
    chk(tag, "primary byte", {24'h0, smram_ctl}, {24'h0, m_pri});
    chk(tag, "extended byte", {24'h0, ext_ctl}, {24'h0, m_ext});
  endtask

  task automatic acc(input logic [31:0] a, input logic s, input string tag);
    logic [1:0] er;
    @(negedge clk);
    acc_addr = a; acc_smm = s;
    #2;
    er = exp_route(a, s);
    chk(tag, "route", {30'h0, route}, {30'h0, er});
    if (er == 2'd0)
      chk(tag, "dram address", dram_addr, in_high(a) ? (a - HIB + LOWB) : a);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pri = 8'h00; m_ext = 8'h00;
    #2;
    chk("R1", "primary after reset", {24'h0, smram_ctl}, 32'h0);
    chk("R1", "extended after reset", {24'h0, ext_ctl}, 32'h0);
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] sz, r;
    sz = seg_size(m_ext);
    r = $urandom;
    case ($urandom_range(0, 6))
      0: return LOWB + (r % WIN);
      1: return HIB + (r % WIN);
      2: return TOP - sz + (r % (sz == 0 ? 32'h10 : sz));
      3: return TOP - sz - 32'd1;
      4: return TOP;
      5: return (r[0]) ? LOWB - 1 : HIB + WIN;
      default: return r;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R9/R4: default routing before any write
    acc(LOWB, 1'b0, "R4");
    acc(TOP - 1, 1'b0, "R9");
    acc(TOP, 1'b1, "R9");

    // R2: masked writes, lock bit avoided
    wr(1'b0, 8'hEF, "R2");
    wr(1'b1, 8'hFF, "R2");
    acc(HIB + 32'h123, 1'b0, "R5");
    acc(LOWB + 32'h40, 1'b1, "R6");

    // random phase (never sets lock)
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) begin
        wr(1'($urandom_range(0, 1)), 8'($urandom) & 8'hEF, "R2");
      end else begin
        logic [31:0] a;
        logic s;
        a = pick_addr();
        s = 1'($urandom_range(0, 1));
        acc(a, s, tag_of(a, s));
      end
    end

    // R7/R8: segment edges for each size code
    for (int c = 0; c < 4; c++) begin
      logic [31:0] sz;
      wr(1'b1, 8'(1 | (c << 1)), "R7");
      sz = seg_size(m_ext);
      for (int s = 0; s < 2; s++) begin
        acc(TOP - sz - 1, 1'(s), "R7");
        acc(TOP - sz, 1'(s), "R7");
        acc(TOP - 1, 1'(s), "R8");
        acc(TOP, 1'(s), "R7");
      end
    end
    wr(1'b1, 8'h06, "R7");
    acc(TOP - 1, 1'b0, "R7");

    // R6: global enable with high enable set
    wr(1'b0, 8'h08, "R6");
    wr(1'b1, 8'h80, "R6");
    acc(HIB + 32'h10, 1'b1, "R6");
    acc(LOWB + 32'h10, 1'b1, "R6");
    acc(HIB + 32'h10, 1'b0, "R5");

    // R3: lock together with open
    wr(1'b0, 8'h58, "R3");
    chk("R3", "open cleared by lock", {31'h0, smram_ctl[6]}, 32'h0);
    wr(1'b0, 8'h40, "R3");
    wr(1'b1, 8'h01, "R3");
    chk("R3", "locked primary", {24'h0, smram_ctl}, 32'h18);
    chk("R3", "locked extended", {24'h0, ext_ctl}, 32'h80);
    acc(LOWB, 1'b0, "R3");
    acc(HIB, 1'b0, "R3");
    acc(HIB, 1'b1, "R3");

    do_reset();
    wr(1'b0, 8'h40, "R1");
    acc(LOWB + 32'h1FFFF, 1'b0, "R4");
    acc(LOWB + 32'h20000, 1'b0, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule